// File: doc/BRIEF.md
# Two-Thread Partitioned Entry Queue with Mode Control

This block is a shared entry queue for a core that runs two logical threads. Each thread pushes and pops its own in-order stream, and all entries of both streams live in one storage array. Each entry is a data word plus a link to the next entry of the same stream. Free slots are taken from one pool, so the split of the array between the threads is a matter of admission. The storage itself has no fixed split.

A three-state mode machine decides how much of the array each thread may hold. In multi-task mode both threads run. A halt pulse from one thread moves the block to single-task mode with the other thread as the only active one. An interrupt pulse then brings the block back to multi-task mode.

Under the partition policy, each thread gets half the array in multi-task mode, and the active thread gets the whole array in single-task mode. Under the threshold policy, every active thread is capped at a programmable limit instead. If a mode change lowers a thread's limit, the entries that thread already holds stay in place. That thread's new pushes are refused until it has drained below the new limit.

Top module: `dual_thread_queue`

## Requirements
- R1: A synchronous active-high reset sets the following: mode reads 2'b00 (multi-task), both occupancy counts read 0, both pop_valid bits are low, and both push_ready bits are high.
- R2: Each thread's entries leave in the order that thread pushed them. This holds whatever the other thread pushes or pops in the meantime.
- R3: With policy_thr low and mode 2'b00, a thread whose occupancy has reached DEPTH/2 has push_ready low.
- R4: With policy_thr low and mode 2'b00, one thread being at its limit does not change the other thread's ability to push or pop.
- R5: In mode 2'b00, a halt pulse from thread 0 moves the mode to 2'b10 (thread 1 alone). A halt pulse from thread 1 moves it to 2'b01 (thread 0 alone). If both pulse in the same cycle, thread 0's halt wins.
- R6: In mode 2'b01 or 2'b10, the active thread may hold up to DEPTH entries. The halted thread has push_ready low, but it can still pop the entries it holds.
- R7: In mode 2'b01 or 2'b10, an interrupt pulse on either thread returns the mode to 2'b00, even if a halt pulse arrives in the same cycle. Halt pulses in these modes are ignored, and interrupt pulses in mode 2'b00 are ignored.
- R8: With policy_thr high, an active thread whose occupancy has reached min(thr_limit, DEPTH) has push_ready low, even while free entries remain.
- R9: When a mode change leaves a thread holding more entries than its new limit, that thread's pushes are refused. They are refused while its occupancy is at or above the limit, and are accepted again once it drops below.
- R10: Each occupancy count rises by one on an accepted push and falls by one on a pop. An accepted push and a pop by the same thread in the same cycle leave the count unchanged. The two counts never sum to more than DEPTH.
- R11: Under the threshold policy the array can fill before either thread reaches its limit. When it is full, push_ready is low for both threads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 2 | Push request per thread (bit t = thread t) |
| push_ready | output | 2 | Push accepted this cycle if valid |
| push_data0 | input | DATA_W | Thread 0 push word |
| push_data1 | input | DATA_W | Thread 1 push word |
| pop_valid | output | 2 | Thread holds at least one entry |
| pop_ready | input | 2 | Pop request per thread |
| pop_data0 | output | DATA_W | Oldest word of thread 0 |
| pop_data1 | output | DATA_W | Oldest word of thread 1 |
| halt | input | 2 | Halt pulse per thread |
| irq | input | 2 | Interrupt pulse per thread |
| policy_thr | input | 1 | 0 = partition policy, 1 = threshold policy |
| thr_limit | input | CNT_W | Per-thread entry cap under the threshold policy |
| occ0 | output | CNT_W | Thread 0 occupancy |
| occ1 | output | CNT_W | Thread 1 occupancy |
| mode | output | 2 | 00 multi-task, 01 thread 0 alone, 10 thread 1 alone |

## Verification
The checker watches several rules on every cycle:
- admission is refused at the half-array limit, at the threshold limit, and for a halted thread;
- the halt and wake-up transitions of the mode machine happen as required;
- the occupancy counts step correctly and never sum past the array size.

Some behaviour only the bench scenarios can show. These are the per-thread ordering of data through the shared linked storage, the drain-then-readmit sequence after a limit shrinks, and a halted thread emptying its remaining entries.

// File: rtl/dtq_pkg.sv
package dtq_pkg;
    typedef enum logic [1:0] {
        MODE_MT  = 2'b00,
        MODE_ST0 = 2'b01,
        MODE_ST1 = 2'b10
    } mode_e;

    localparam int NTHR = 2;
endpackage

// File: rtl/dtq_mode_ctrl.sv
module dtq_mode_ctrl
    import dtq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NTHR-1:0] halt,
    input  logic [NTHR-1:0] irq,
    output mode_e           mode
);
    typedef struct packed {
        mode_e mode;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.mode)
            MODE_MT: begin
                // a halting thread leaves the other one running alone
                if (halt[0])      s_d.mode = MODE_ST1;
                else if (halt[1]) s_d.mode = MODE_ST0;
            end
            MODE_ST0, MODE_ST1: begin
                if (|irq) s_d.mode = MODE_MT;
            end
            default: s_d.mode = MODE_MT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '{mode: MODE_MT};
        else     s_q <= s_d;
    end

    assign mode = s_q.mode;
endmodule

// File: rtl/dtq_cap_calc.sv
module dtq_cap_calc
    import dtq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  mode_e                      mode,
    input  logic                       policy_thr,
    input  logic [CNT_W-1:0]           thr_limit,
    output logic [NTHR-1:0][CNT_W-1:0] cap
);
    localparam logic [CNT_W-1:0] FULL_CAP = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_CAP = CNT_W'(DEPTH / 2);

    logic [CNT_W-1:0] thr_cap;
    assign thr_cap = (thr_limit > FULL_CAP) ? FULL_CAP : thr_limit;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        localparam mode_e SOLO = (t == 0) ? MODE_ST0 : MODE_ST1;
        logic active;
        assign active = (mode == MODE_MT) || (mode == SOLO);
        always_comb begin
            if (!active)             cap[t] = '0;
            else if (policy_thr)     cap[t] = thr_cap;
            else if (mode == MODE_MT) cap[t] = HALF_CAP;
            else                     cap[t] = FULL_CAP;
        end
    end
endmodule

// File: rtl/dtq_store.sv
module dtq_store
    import dtq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NTHR-1:0]             push_fire,
    input  logic [NTHR-1:0][DATA_W-1:0] push_data,
    input  logic [NTHR-1:0]             pop_fire,
    output logic [NTHR-1:0][DATA_W-1:0] pop_data,
    output logic [NTHR-1:0][CNT_W-1:0]  cnt
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [DEPTH-1:0][IDX_W-1:0]  nxt;
        logic [DEPTH-1:0]             used;
        logic [NTHR-1:0][IDX_W-1:0]   head;
        logic [NTHR-1:0][IDX_W-1:0]   tail;
        logic [NTHR-1:0][CNT_W-1:0]   cnt;
    } st_t;

    st_t s_d, s_q;

    logic [NTHR-1:0][IDX_W-1:0] slot;
    logic [DEPTH-1:0]           mask1;
    logic [NTHR-1:0][CNT_W-1:0] remain;

    function automatic logic [IDX_W-1:0] first_free(input logic [DEPTH-1:0] m);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!m[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    always_comb begin
        s_d   = s_q;
        // thread 0 takes the lowest free slot, thread 1 the next one
        slot[0] = first_free(s_q.used);
        mask1   = s_q.used;
        if (push_fire[0]) mask1[slot[0]] = 1'b1;
        slot[1] = first_free(mask1);
        for (int t = 0; t < NTHR; t++) begin
            remain[t] = s_q.cnt[t] - CNT_W'(pop_fire[t]);
            if (pop_fire[t]) begin
                s_d.used[s_q.head[t]] = 1'b0;
                s_d.head[t]           = s_q.nxt[s_q.head[t]];
            end
            if (push_fire[t]) begin
                s_d.mem[slot[t]]  = push_data[t];
                s_d.used[slot[t]] = 1'b1;
                if (remain[t] == '0) s_d.head[t] = slot[t];
                else                 s_d.nxt[s_q.tail[t]] = slot[t];
                s_d.tail[t] = slot[t];
            end
            s_d.cnt[t] = remain[t] + CNT_W'(push_fire[t]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    for (genvar t = 0; t < NTHR; t++) begin : g_out
        assign pop_data[t] = s_q.mem[s_q.head[t]];
        assign cnt[t]      = s_q.cnt[t];
    end
endmodule

// File: rtl/dual_thread_queue.sv
module dual_thread_queue
    import dtq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        push_valid,
    output logic [1:0]        push_ready,
    input  logic [DATA_W-1:0] push_data0,
    input  logic [DATA_W-1:0] push_data1,
    output logic [1:0]        pop_valid,
    input  logic [1:0]        pop_ready,
    output logic [DATA_W-1:0] pop_data0,
    output logic [DATA_W-1:0] pop_data1,
    input  logic [1:0]        halt,
    input  logic [1:0]        irq,
    input  logic              policy_thr,
    input  logic [CNT_W-1:0]  thr_limit,
    output logic [CNT_W-1:0]  occ0,
    output logic [CNT_W-1:0]  occ1,
    output logic [1:0]        mode
);
    mode_e                       mode_q;
    logic [NTHR-1:0][CNT_W-1:0]  cap;
    logic [NTHR-1:0][CNT_W-1:0]  cnt;
    logic [NTHR-1:0][DATA_W-1:0] pdata;
    logic [NTHR-1:0][DATA_W-1:0] qdata;
    logic [NTHR-1:0]             push_fire;
    logic [NTHR-1:0]             pop_fire;
    logic [CNT_W-1:0]            free_cnt;

    dtq_mode_ctrl u_mode (
        .clk  (clk),
        .rst  (rst),
        .halt (halt),
        .irq  (irq),
        .mode (mode_q)
    );

    dtq_cap_calc #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cap (
        .mode       (mode_q),
        .policy_thr (policy_thr),
        .thr_limit  (thr_limit),
        .cap        (cap)
    );

    assign pdata[0] = push_data0;
    assign pdata[1] = push_data1;

    always_comb begin
        free_cnt      = CNT_W'(DEPTH) - cnt[0] - cnt[1];
        push_ready[0] = (cnt[0] < cap[0]) && (free_cnt != '0);
        push_fire[0]  = push_valid[0] && push_ready[0];
        // thread 1 needs a second free slot when thread 0 takes one now
        push_ready[1] = (cnt[1] < cap[1]) && (free_cnt > CNT_W'(push_fire[0]));
        push_fire[1]  = push_valid[1] && push_ready[1];
        for (int t = 0; t < NTHR; t++) begin
            pop_valid[t] = (cnt[t] != '0);
            pop_fire[t]  = pop_valid[t] && pop_ready[t];
        end
    end

    dtq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push_fire (push_fire),
        .push_data (pdata),
        .pop_fire  (pop_fire),
        .pop_data  (qdata),
        .cnt       (cnt)
    );

    assign pop_data0 = qdata[0];
    assign pop_data1 = qdata[1];
    assign occ0      = cnt[0];
    assign occ1      = cnt[1];
    assign mode      = mode_q;
endmodule

// File: rtl/dtq_chk.sv
module dtq_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       push_valid,
    input logic [1:0]       push_ready,
    input logic [1:0]       pop_valid,
    input logic [1:0]       pop_ready,
    input logic [1:0]       halt,
    input logic [1:0]       irq,
    input logic             policy_thr,
    input logic [CNT_W-1:0] thr_limit,
    input logic [CNT_W-1:0] occ0,
    input logic [CNT_W-1:0] occ1,
    input logic [1:0]       mode
);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);

    // R10
    occ_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(occ0) + int'(occ1)) <= DEPTH);

    // R3
    part_cap0_chk: assert property (@(posedge clk) disable iff (rst)
        (!policy_thr && mode == 2'b00 && occ0 >= HALF) |-> !push_ready[0]);

    // R3
    part_cap1_chk: assert property (@(posedge clk) disable iff (rst)
        (!policy_thr && mode == 2'b00 && occ1 >= HALF) |-> !push_ready[1]);

    // R6
    halted_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 |-> !push_ready[1]) and (mode == 2'b10 |-> !push_ready[0]));

    // R8
    thr_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (policy_thr && occ0 >= thr_limit) |-> !push_ready[0]);

    // R5
    halt_mt_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && halt[0]) |=> mode == 2'b10);

    // R7
    wake_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b00 && irq != 2'b00) |=> mode == 2'b00);

    // R10
    occ_step_chk: assert property (@(posedge clk) disable iff (rst)
        (push_valid[0] && push_ready[0] && !(pop_valid[0] && pop_ready[0]))
        |=> occ0 == $past(occ0) + 1'b1);

    // R5
    mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        mode != 2'b11);
endmodule

bind dual_thread_queue dtq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .push_valid (push_valid),
    .push_ready (push_ready),
    .pop_valid  (pop_valid),
    .pop_ready  (pop_ready),
    .halt       (halt),
    .irq        (irq),
    .policy_thr (policy_thr),
    .thr_limit  (thr_limit),
    .occ0       (occ0),
    .occ1       (occ1),
    .mode       (mode)
);

// File: tb/tb_dual_thread_queue.sv
module tb_dual_thread_queue;
    localparam int DEPTH = 8;
    localparam int DW    = 8;
    localparam int CW    = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    push_valid = '0, push_ready, pop_valid, pop_ready = '0;
    logic [DW-1:0] push_data0 = '0, push_data1 = '0, pop_data0, pop_data1;
    logic [1:0]    halt = '0, irq = '0, mode;
    logic          policy_thr = 1'b0;
    logic [CW-1:0] thr_limit = '0, occ0, occ1;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dual_thread_queue #(.DEPTH(DEPTH), .DATA_W(DW), .CNT_W(CW)) dut (.*);

    // {halt[1:0], irq[1:0], expected mode}
    localparam logic [5:0] MODE_VEC [11] = '{
        6'b01_00_10, 6'b10_00_10, 6'b00_01_00, 6'b00_01_00,
        6'b10_00_01, 6'b01_00_01, 6'b00_01_00, 6'b11_00_10,
        6'b01_10_00, 6'b10_00_01, 6'b00_10_00
    };

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input int t, input logic [DW-1:0] d, output bit acc);
        push_valid[t] = 1'b1;
        if (t == 0) push_data0 = d; else push_data1 = d;
        #1 acc = push_ready[t];
        @(posedge clk); #1;
        push_valid = '0;
    endtask

    task automatic pop(input int t, output logic [DW-1:0] d, output bit v);
        v = pop_valid[t];
        d = (t == 0) ? pop_data0 : pop_data1;
        pop_ready[t] = 1'b1;
        @(posedge clk); #1;
        pop_ready = '0;
    endtask

    task automatic pulse(input logic [1:0] h, input logic [1:0] i);
        halt = h; irq = i;
        @(posedge clk); #1;
        halt = '0; irq = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        bit acc, v;
        int na;
        logic [DW-1:0] d;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk("R1 mode", mode, 0);
        chk("R1 occ0", occ0, 0);
        chk("R1 occ1", occ1, 0);
        chk("R1 pop_valid", pop_valid, 0);
        chk("R1 push_ready", push_ready, 3);

        // R5 R7 mode machine vectors
        for (int i = 0; i < 11; i++) begin
            pulse(MODE_VEC[i][5:4], MODE_VEC[i][3:2]);
            chk($sformatf("R5 R7 mode vec %0d", i), mode, MODE_VEC[i][1:0]);
        end

        // R3 partition cap in multi-task mode
        na = 0;
        for (int i = 0; i < 6; i++) begin
            push(0, 8'h10 + 8'(i), acc);
            na += int'(acc);
        end
        chk("R3 accepted", na, DEPTH / 2);
        chk("R3 occ0", occ0, DEPTH / 2);
        chk("R3 ready0", push_ready[0], 0);
        // R4 other thread unaffected
        chk("R4 ready1", push_ready[1], 1);
        push(1, 8'hA0, acc); chk("R4 push1 a", acc, 1);
        push(1, 8'hA1, acc); chk("R4 push1 b", acc, 1);
        pop(1, d, v);        chk("R4 R2 pop1", d, 8'hA0);
        pop(0, d, v);        chk("R2 pop0 first", d, 8'h10);
        // R10 push and pop same thread same cycle
        push_valid[1] = 1'b1; push_data1 = 8'hA2; pop_ready[1] = 1'b1;
        #1 d = pop_data1;
        @(posedge clk); #1;
        push_valid = '0; pop_ready = '0;
        chk("R10 simult data", d, 8'hA1);
        chk("R10 simult occ1", occ1, 1);
        for (int i = 1; i < 4; i++) begin
            pop(0, d, v); chk("R2 pop0 order", d, 8'h10 + 8'(i));
        end
        pop(1, d, v); chk("R2 pop1 last", d, 8'hA2);
        chk("R10 empty", int'(occ0) + int'(occ1), 0);

        // R6 single-task: halted thread drains, active fills all
        push(1, 8'hB0, acc);
        pulse(2'b10, 2'b00);
        chk("R6 mode st0", mode, 1);
        chk("R6 halted ready1", push_ready[1], 0);
        pop(1, d, v);
        chk("R6 halted pop valid", v, 1);
        chk("R6 halted pop data", d, 8'hB0);
        na = 0;
        for (int i = 0; i < DEPTH; i++) begin
            push(0, 8'h20 + 8'(i), acc);
            na += int'(acc);
        end
        chk("R6 full accepted", na, DEPTH);
        chk("R6 ready0 full", push_ready[0], 0);

        // R9 shrink on wake-up: refused until below half
        pulse(2'b00, 2'b10);
        chk("R9 mode mt", mode, 0);
        chk("R9 ready0 over", push_ready[0], 0);
        for (int i = 0; i < 4; i++) begin
            pop(0, d, v); chk("R9 R2 drain order", d, 8'h20 + 8'(i));
        end
        chk("R9 ready0 at limit", push_ready[0], 0);
        pop(0, d, v);
        chk("R9 ready0 below", push_ready[0], 1);
        for (int i = 5; i < 8; i++) begin
            pop(0, d, v); chk("R2 drain tail", d, 8'h20 + 8'(i));
        end

        // R8 threshold cap with free entries left
        policy_thr = 1'b1; thr_limit = 4'd3;
        na = 0;
        for (int i = 0; i < 5; i++) begin
            push(0, 8'h30 + 8'(i), acc);
            na += int'(acc);
        end
        chk("R8 accepted", na, 3);
        chk("R8 ready0", push_ready[0], 0);
        // R11 array fills before thread 1 reaches its cap
        thr_limit = 4'd6;
        for (int i = 3; i < 6; i++) push(0, 8'h30 + 8'(i), acc);
        chk("R11 occ0", occ0, 6);
        na = 0;
        for (int i = 0; i < 4; i++) begin
            push(1, 8'hC0 + 8'(i), acc);
            na += int'(acc);
        end
        chk("R11 accepted1", na, 2);
        chk("R11 ready", push_ready, 0);
        for (int i = 0; i < 6; i++) begin
            pop(0, d, v); chk("R2 thr order0", d, 8'h30 + 8'(i));
        end
        for (int i = 0; i < 2; i++) begin
            pop(1, d, v); chk("R2 thr order1", d, 8'hC0 + 8'(i));
        end
        chk("R10 final empty", pop_valid, 0);

        summary();
        $finish;
    end
endmodule